// File: doc/BRIEF.md
# Programmable Pseudorandom and Repeating Test Pattern Source

This block drives a serial test bit stream for link testing, one bit for every clock in which transmission is enabled. There are two pattern modes. In the first, a shift register produces a pseudorandom sequence. Its length, from 1 to 32 stages, and its feedback taps are both set at run time. In the second, a user word of 1 to 32 bits is sent most-significant bit first and then repeats without end.

Software-side logic presents a seed or word, a length, a tap mask, a mode and an error-rate code on the configuration inputs. A single-cycle load strobe then copies these into the running engine. A disable input freezes the engine for clock periods that carry no test data, as on gap-clocked links. Errors can be placed deliberately in two ways: a one-shot request flips one outgoing bit, and a decade rate code flips every 10th, 100th and so on, up to every 10,000,000th, enabled bit.

Top module: `pattern_tx_gen`

## Requirements
- R1: After reset, and until the first load strobe, `tx_data` is 0 and no bit is produced.
- R2: A change on any configuration input has no effect on the output stream until a load strobe samples it.
- R3: In pseudorandom mode (`cfg_mode`=0), with L = `cfg_len`+1, each enabled bit outputs stage L-1 of the state. The state then becomes (state<<1 | f) masked to L bits, where f is the XOR of every stage i < L with `cfg_taps[i]`=1.
- R4: In pseudorandom mode, a seed whose low L bits are all zero is replaced at load by L ones.
- R5: In repeat mode (`cfg_mode`=1), the low L bits of `cfg_word` are sent from bit L-1 down to bit 0, and the word then repeats. This holds for every L from 1 to 32.
- R6: While `tx_dis` is 1, both `tx_data` and the generator state hold.
- R7: A pulse on `err_single` inverts exactly one later bit: the first enabled bit after the request is registered. The pattern sequence itself does not shift.
- R8: With `cfg_rate` code k from 1 to 7 latched at load, the n-th enabled bit after that load is inverted whenever n is a multiple of 10^k. Code 0 injects no rate errors.
- R9: `tx_data` is registered. It changes only on enabled clock edges after a load. The load edge itself sets it to 0 and produces no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | 0 pseudorandom, 1 repeating word |
| cfg_len | input | 5 | Pattern length minus one |
| cfg_word | input | 32 | Seed (pseudorandom) or word (repeat) |
| cfg_taps | input | 32 | Feedback stage mask |
| cfg_rate | input | 3 | Decade error rate code, 0 off |
| load | input | 1 | Copies configuration into the engine |
| err_single | input | 1 | Request one inverted bit |
| tx_dis | input | 1 | Hold generator for this clock |
| tx_data | output | 1 | Serial test data |

## Verification
The bench goes after the lock-up seed. A design that did not replace an all-zero seed would send constant zeros instead of the ones run expected after the load. It checks lengths 1 and 32 of the repeat word, where a wrong mask or index would cut the word short or read past the top stage. It mixes `tx_dis` gaps into error-rate runs. A counter that advanced on disabled clocks, or a one-shot that cleared on one, would flip the wrong bit or lose the flip. It also changes the configuration without a load. A design that looked through to live inputs would change the stream at once.

// File: rtl/patgen_pkg.sv
package patgen_pkg;

  typedef enum logic {
    PAT_PRBS   = 1'b0,
    PAT_REPEAT = 1'b1
  } pat_mode_e;

  localparam int RATE_W = 3;

  // Reload value of the decade counter: 10^code - 1 (0 for code 0).
  function automatic logic [31:0] decade_limit(input logic [RATE_W-1:0] code);
    logic [31:0] v;
    v = 32'd1;
    for (int i = 1; i < (1 << RATE_W); i++) begin
      if (i <= int'(code)) v = v * 32'd10;
    end
    return v - 32'd1;
  endfunction

endpackage

// File: rtl/patgen_engine.sv
module patgen_engine
  import patgen_pkg::*;
#(
  parameter int W  = 32,
  parameter int LW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          bit_en,
  input  pat_mode_e     ld_mode,
  input  logic [LW-1:0] ld_lenm1,
  input  logic [W-1:0]  ld_taps,
  input  logic [W-1:0]  ld_seed,
  output logic          gen_bit,
  output logic [W-1:0]  gen_state
);

  pat_mode_e     mode_q;
  logic [LW-1:0] lenm1_q;
  logic [W-1:0]  taps_q;
  logic [W-1:0]  state_q;

  function automatic logic [W-1:0] len_mask(input logic [LW-1:0] lm1);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i <= int'(lm1));
    return m;
  endfunction

  function automatic logic [W-1:0] seed_fix(input pat_mode_e md, input logic [W-1:0] s,
                                            input logic [LW-1:0] lm1);
    logic [W-1:0] m;
    m = len_mask(lm1);
    if (md == PAT_PRBS && (s & m) == '0) return m;
    return s & m;
  endfunction

  function automatic logic [W-1:0] advance(input pat_mode_e md, input logic [W-1:0] s,
                                           input logic [W-1:0] t, input logic [LW-1:0] lm1);
    logic fb;
    logic [W-1:0] m;
    m  = len_mask(lm1);
    fb = (md == PAT_REPEAT) ? s[lm1] : ^(s & t & m);
    return ((s << 1) | {{(W-1){1'b0}}, fb}) & m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= PAT_PRBS;
      lenm1_q <= '0;
      taps_q  <= '0;
      state_q <= '0;
    end else if (load) begin
      mode_q  <= ld_mode;
      lenm1_q <= ld_lenm1;
      taps_q  <= ld_taps;
      state_q <= seed_fix(ld_mode, ld_seed, ld_lenm1);
    end else if (bit_en) begin
      state_q <= advance(mode_q, state_q, taps_q, lenm1_q);
    end
  end

  assign gen_bit   = state_q[lenm1_q];
  assign gen_state = state_q;

endmodule

// File: rtl/patgen_errinj.sv
module patgen_errinj
  import patgen_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [RATE_W-1:0] ld_rate,
  input  logic              bit_en,
  input  logic              err_single,
  output logic              err_flip,
  output logic              single_pend,
  output logic              single_hit,
  output logic              rate_hit,
  output logic [RATE_W-1:0] rate_code
);

  logic [RATE_W-1:0] rate_q;
  logic [CW-1:0]     cnt_q;
  logic              pend_q;

  assign rate_hit   = bit_en && (rate_q != '0) && (cnt_q == '0);
  assign single_hit = bit_en && pend_q;
  assign err_flip   = rate_hit | single_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      rate_q <= ld_rate;
      cnt_q  <= CW'(decade_limit(ld_rate));
    end else if (bit_en && rate_q != '0) begin
      cnt_q <= (cnt_q == '0) ? CW'(decade_limit(rate_q)) : cnt_q - 1'b1;
    end
  end

  // One-shot: a held request keeps re-arming; otherwise cleared by the next enabled bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= err_single | (pend_q & ~bit_en);
  end

  assign single_pend = pend_q;
  assign rate_code   = rate_q;

endmodule

// File: rtl/pattern_tx_gen.sv
module pattern_tx_gen
  import patgen_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 24,
  localparam int LW = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_mode,
  input  logic [LW-1:0]     cfg_len,
  input  logic [W-1:0]      cfg_word,
  input  logic [W-1:0]      cfg_taps,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              load,
  input  logic              err_single,
  input  logic              tx_dis,
  output logic              tx_data
);

  logic              running;
  logic              bit_en;
  logic              gen_bit;
  logic [W-1:0]      gen_state;
  logic              err_flip;
  logic              single_pend;
  logic              single_hit;
  logic              rate_hit;
  logic [RATE_W-1:0] rate_code;

  assign bit_en = running & ~tx_dis & ~load;

  patgen_engine #(.W(W), .LW(LW)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .bit_en   (bit_en),
    .ld_mode  (pat_mode_e'(cfg_mode)),
    .ld_lenm1 (cfg_len),
    .ld_taps  (cfg_taps),
    .ld_seed  (cfg_word),
    .gen_bit  (gen_bit),
    .gen_state(gen_state)
  );

  patgen_errinj #(.CW(CW)) u_err (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .ld_rate    (cfg_rate),
    .bit_en     (bit_en),
    .err_single (err_single),
    .err_flip   (err_flip),
    .single_pend(single_pend),
    .single_hit (single_hit),
    .rate_hit   (rate_hit),
    .rate_code  (rate_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      tx_data <= 1'b0;
    end else if (load) begin
      running <= 1'b1;
      tx_data <= 1'b0;
    end else if (bit_en) begin
      tx_data <= gen_bit ^ err_flip;
    end
  end

endmodule

// File: rtl/pattern_tx_gen_chk.sv
module pattern_tx_gen_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load,
  input logic         tx_dis,
  input logic         cfg_mode,
  input logic         err_single,
  input logic         tx_data,
  input logic         running,
  input logic         bit_en,
  input logic         single_pend,
  input logic         single_hit,
  input logic         rate_hit,
  input logic [2:0]   rate_code,
  input logic [W-1:0] gen_state
);

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !tx_data);

  // R9
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!tx_data && running));

  // R6
  dis_hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dis && !load) |=> $stable(tx_data));

  // R6
  dis_hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dis && !load) |=> $stable(gen_state));

  // R4
  seed_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !cfg_mode) |=> (gen_state != '0));

  // R7
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (single_hit && !err_single) |=> !single_pend);

  // R8
  rate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == 3'd0) |-> !rate_hit);

  // R8
  rate_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_hit |-> bit_en);

endmodule

bind pattern_tx_gen pattern_tx_gen_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load       (load),
  .tx_dis     (tx_dis),
  .cfg_mode   (cfg_mode),
  .err_single (err_single),
  .tx_data    (tx_data),
  .running    (running),
  .bit_en     (bit_en),
  .single_pend(single_pend),
  .single_hit (single_hit),
  .rate_hit   (rate_hit),
  .rate_code  (rate_code),
  .gen_state  (gen_state)
);

// File: tb/test_pattern_tx_gen.sv
module test_pattern_tx_gen;
  localparam int W  = 32;
  localparam int LW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_mode = 1'b0;
  logic [LW-1:0] cfg_len = '0;
  logic [W-1:0]  cfg_word = '0;
  logic [W-1:0]  cfg_taps = '0;
  logic [2:0]    cfg_rate = '0;
  logic          load = 1'b0;
  logic          err_single = 1'b0;
  logic          tx_dis = 1'b0;
  logic          tx_data;

  pattern_tx_gen i_pattern_tx_gen (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_len(cfg_len),
    .cfg_word(cfg_word), .cfg_taps(cfg_taps), .cfg_rate(cfg_rate),
    .load(load), .err_single(err_single), .tx_dis(tx_dis), .tx_data(tx_data)
  );

  always #4 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Behavioural reference
  bit               m_out, m_run, m_pend, m_mode, m_en;
  int               m_len, m_rate, m_bitno;
  longint unsigned  m_st, m_mask;
  logic [W-1:0]     m_taps;
  bit               m_q[$];
  bit               cap[$];

  always @(posedge clk) begin
    bit en, b, fb, inj;
    m_en = 0;
    if (!rst_n) begin
      m_out = 0; m_run = 0; m_pend = 0;
    end else if (load) begin
      m_run = 1; m_out = 0; m_mode = cfg_mode; m_len = int'(cfg_len) + 1;
      m_taps = cfg_taps; m_rate = int'(cfg_rate); m_bitno = 0;
      m_mask = (64'd1 << m_len) - 64'd1;
      if (m_mode) begin
        m_q.delete();
        for (int i = m_len - 1; i >= 0; i--) m_q.push_back(cfg_word[i]);
      end else begin
        m_st = longint'(cfg_word) & m_mask;
        if (m_st == 0) m_st = m_mask;
      end
      m_pend = m_pend | err_single;
    end else begin
      en = m_run && !tx_dis;
      inj = 0;
      if (en) begin
        m_en = 1;
        m_bitno++;
        if (m_mode) begin
          b = m_q.pop_front();
          m_q.push_back(b);
        end else begin
          b = m_st[m_len-1];
          fb = 0;
          for (int i = 0; i < m_len; i++) if (m_taps[i]) fb ^= m_st[i];
          m_st = ((m_st << 1) | longint'(fb)) & m_mask;
        end
        if (m_pend) inj = 1;
        if (m_rate != 0 && (m_bitno % (10 ** m_rate)) == 0) inj = 1;
        m_out = b ^ inj;
      end
      m_pend = err_single | (m_pend & !en);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tx_data === m_out, cur_req, int'(tx_data), int'(m_out));
      if (m_en) cap.push_back(tx_data);
    end
  end

  task automatic run(input int n, input bit gaps);
    repeat (n) begin
      @(negedge clk);
      tx_dis = gaps ? ($urandom % 3 == 0) : 1'b0;
    end
    @(negedge clk);
    tx_dis = 1'b0;
  endtask

  task automatic do_load(input bit md, input int len, input logic [W-1:0] word,
                         input logic [W-1:0] taps, input logic [2:0] rate);
    @(negedge clk);
    cfg_mode = md; cfg_len = LW'(len - 1); cfg_word = word; cfg_taps = taps; cfg_rate = rate;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    // R9: load edge clears output
    check(tx_data == 1'b0, "R9", int'(tx_data), 0);
    cap.delete();
  endtask

  task automatic count_ones(input int n, output int ones);
    ones = 0;
    for (int i = 0; i < n; i++) ones += int'(cap[i]);
  endtask

  initial begin
    int ones;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle before load
    cur_req = "R1";
    run(6, 0);
    check(tx_data == 1'b0, "R1", int'(tx_data), 0);

    // R3: 7-stage sequence, taps at stages 6 and 5, period 127
    cur_req = "R3";
    do_load(0, 7, 32'h1, 32'h60, 3'd0);
    run(300, 0);
    ok = (cap.size() >= 254);
    for (int i = 0; i < 127 && ok; i++) if (cap[i] != cap[i+127]) ok = 0;
    check(ok, "R3", int'(ok), 1);

    // R2: configuration changes without load are ignored
    cur_req = "R2";
    @(negedge clk);
    cfg_mode = 1'b1; cfg_len = 5'd3; cfg_word = 32'h0; cfg_taps = 32'hFFFF_FFFF; cfg_rate = 3'd1;
    run(60, 0);

    // R6: gaps
    cur_req = "R6";
    run(200, 1);

    // R4: zero seed becomes all ones (9 stages, taps 8 and 4)
    cur_req = "R4";
    do_load(0, 9, 32'h0, 32'h110, 3'd0);
    run(100, 0);
    count_ones(9, ones);
    check(ones == 9, "R4", ones, 9);

    // R5: repeating words of length 4, 32 and 1
    cur_req = "R5";
    do_load(1, 4, 32'hB, 32'h0, 3'd0);
    run(40, 1);
    do_load(1, 32, 32'hDEADBEEF, 32'h0, 3'd0);
    run(100, 0);
    do_load(1, 1, 32'h1, 32'h0, 3'd0);
    run(20, 0);
    count_ones(10, ones);
    check(ones == 10, "R5", ones, 10);

    // R7: one-shot error on an all-zero word
    cur_req = "R7";
    do_load(1, 8, 32'h0, 32'h0, 3'd0);
    run(5, 0);
    @(negedge clk); err_single = 1'b1;
    @(negedge clk); err_single = 1'b0;
    run(40, 1);
    count_ones(cap.size(), ones);
    check(ones == 1, "R7", ones, 1);

    // R8: rate 1 in 10 on zeros, then code 0, then 1 in 100 with gaps
    cur_req = "R8";
    do_load(1, 1, 32'h0, 32'h0, 3'd1);
    run(100, 0);
    count_ones(100, ones);
    check(ones == 10, "R8", ones, 10);
    check(cap[9] == 1'b1 && cap[8] == 1'b0, "R8", int'(cap[9]), 1);
    do_load(1, 1, 32'h0, 32'h0, 3'd0);
    run(60, 0);
    count_ones(60, ones);
    check(ones == 0, "R8", ones, 0);
    do_load(0, 15, 32'h1234, 32'h6000, 3'd2);
    run(600, 1);

    // R3: 31 stages, taps 30 and 27, with single errors mixed in
    cur_req = "R3";
    do_load(0, 31, 32'h5A5A5A5A, 32'h4800_0000, 3'd0);
    run(200, 0);
    @(negedge clk); err_single = 1'b1;
    @(negedge clk); err_single = 1'b0;
    run(300, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule